// File: doc/BRIEF.md
# Stop-Clock Grant Controller

This controller runs the stop-clock handshake of a processor bus agent. When the platform raises a stop-clock request, it asks the bus interface for one grant-acknowledge cycle. It then waits for the response phase of that cycle. After a fixed count of bus clocks it parks the agent in the Stop Grant state. While parked, the agent still answers bus snoops through a short Grant Snoop sub-state.

Side-band interrupt events (INIT, SMI and two local interrupt lines) that arrive while the agent is parked are held one deep per source. They are handed on one per clock, in fixed priority order, once the agent is back in Normal. If the request was raised while the agent was halted, removing it returns the agent to Halt. A reset while parked reinitializes the internal state but leaves the agent in Stop Grant.

The state is visible on `state_o` with this encoding: Normal=0, Halt=1, Ack Wait=2, Entry Delay=3, Stop Grant=4, Grant Snoop=5. The bits of both `evt_in` and `evt_rel` are assigned as follows: bit 0 is INIT, bit 1 is SMI, bit 2 is local interrupt 0 and bit 3 is local interrupt 1.

Top module: `clkstop_grant_ctrl`

## Requirements
- R1: A synchronous reset outside Stop Grant/Grant Snoop puts `state_o` at 0 (Normal), drops `ack_cycle_req`, drives `evt_rel` to 0 and clears all pending events.
- R2: In Normal (0) or Halt (1), a sampled `stop_req` moves the state to Ack Wait (2) on the next clock; `ack_cycle_req` is high exactly while the state is 2.
- R3: Consider the clock edge that samples `ack_resp` high while the state is Ack Wait. At that edge the state becomes Entry Delay (3). Exactly ENTRY_CLKS (default 20) clock edges after it, the state becomes Stop Grant (4).
- R4: In Stop Grant, with Stop Grant having been entered from Normal, a low `stop_req` returns the state to Normal on the next clock.
- R5: When the request was taken in Halt, a low `stop_req` in Stop Grant returns the state to Halt (1) instead of Normal.
- R6: In Stop Grant with `stop_req` high, a sampled `snoop_hit` moves the state to Grant Snoop (5). Grant Snoop lasts one clock and then returns to Stop Grant.
- R7: A reset while in Stop Grant or Grant Snoop leaves the state at 4, clears pending events, and makes the later release go to Normal even if entry was from Halt.
- R8: An `evt_in` bit sampled high in state 4 or 5 sets that source's pending flag. Any number of assertions gives a single release. Events sampled in any other state are not held.
- R9: In Normal, pending events leave on `evt_rel` as one-clock, one-hot pulses, one per clock, in the order INIT, SMI, local 0, local 1. The first pulse appears one clock after Normal is reached.
- R10: In Normal, a sampled `halt_exec` without `stop_req` moves to Halt. In Halt, `snoop_hit` leaves the state unchanged and any `evt_in` bit returns it to Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Stop-clock request from the platform |
| ack_resp | input | 1 | Response-phase strobe of the grant-acknowledge cycle |
| snoop_hit | input | 1 | A bus snoop needs service |
| halt_exec | input | 1 | The core executed a halt |
| evt_in | input | NUM_EV | Side-band events: INIT, SMI, local 0, local 1 |
| state_o | output | 3 | Current controller state |
| ack_cycle_req | output | 1 | Request to issue the grant-acknowledge cycle |
| evt_rel | output | NUM_EV | One-clock release pulses of held events |

## Verification
The embedded assertions check the following on every cycle:
- the step from request to Ack Wait;
- the hold in Entry Delay until the timer completes, and the entry into Stop Grant when it does;
- the one-clock Grant Snoop turnaround;
- the exit target chosen by the remembered halt origin;
- the halt wake-up;
- one-hot releases that occur only out of Normal and only for events that were pending.

Several behaviours can only be shown by the bench's scenarios:
- the absolute 20-clock distance from the response strobe;
- reset keeping the parked state and discarding held events;
- the collapse of repeated events into one release;
- the exact release order after a mixed burst.

The random phase compares every cycle against a bench model of the requirements.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_HALT   = 3'd1,
    ST_ACK    = 3'd2,
    ST_DELAY  = 3'd3,
    ST_GRANT  = 3'd4,
    ST_SNOOP  = 3'd5
  } cs_state_e;

  localparam int EV_INIT  = 0;
  localparam int EV_SMI   = 1;
  localparam int EV_LINT0 = 2;
  localparam int EV_LINT1 = 3;
  localparam int NUM_EV   = 4;

  function automatic logic is_parked(cs_state_e s);
    return (s == ST_GRANT) || (s == ST_SNOOP);
  endfunction

endpackage

// File: rtl/clkstop_entry_timer.sv
module clkstop_entry_timer #(
  parameter int ENTRY_CLKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(ENTRY_CLKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(ENTRY_CLKS);

  logic [CW-1:0] cnt_q;

  // cnt_q holds the number of edges seen since the response strobe
  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (start)                 cnt_q <= CW'(1);
    else if (run && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LIMIT);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !done && !start) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/clkstop_prio_pick.sv
module clkstop_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // lowest index wins
  for (genvar i = 0; i < N; i++) begin : g_pick
    if (i == 0) begin : g_top
      assign gnt[i] = req[i];
    end else begin : g_rest
      assign gnt[i] = req[i] & ~(|req[i-1:0]);
    end
  end

endmodule

// File: rtl/clkstop_event_latch.sv
module clkstop_event_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic         drain,
  input  logic [N-1:0] evt,
  output logic [N-1:0] rel
);
  logic [N-1:0] pend_q;
  logic [N-1:0] rel_q;
  logic [N-1:0] gnt;
  logic [N-1:0] take;

  clkstop_prio_pick #(.N(N)) u_pick (
    .req (pend_q),
    .gnt (gnt)
  );

  assign take = drain ? gnt : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      rel_q  <= '0;
    end else begin
      rel_q  <= take;
      pend_q <= (pend_q & ~take) | (capture ? evt : '0);
    end
  end

  assign rel = rel_q;

  assert_release_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rel_q));

  assert_release_was_pending_R9: assert property (@(posedge clk) disable iff (rst)
    (|rel_q) |-> ((rel_q & ~$past(pend_q)) == '0));

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!capture && !drain) |=> $stable(pend_q));

endmodule

// File: rtl/clkstop_grant_ctrl.sv
module clkstop_grant_ctrl
  import clkstop_pkg::*;
#(
  parameter int ENTRY_CLKS = 20,
  parameter int NUM_EV     = clkstop_pkg::NUM_EV
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_req,
  input  logic              ack_resp,
  input  logic              snoop_hit,
  input  logic              halt_exec,
  input  logic [NUM_EV-1:0] evt_in,
  output logic [2:0]        state_o,
  output logic              ack_cycle_req,
  output logic [NUM_EV-1:0] evt_rel
);
  cs_state_e state_q = ST_NORMAL;
  cs_state_e state_d;
  logic      from_halt_q, from_halt_d;
  logic      ack_q;
  logic      entry_done;

  clkstop_entry_timer #(.ENTRY_CLKS(ENTRY_CLKS)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start ((state_q == ST_ACK) && ack_resp),
    .run   (state_q == ST_DELAY),
    .done  (entry_done)
  );

  clkstop_event_latch #(.N(NUM_EV)) u_events (
    .clk     (clk),
    .rst     (rst),
    .capture (is_parked(state_q)),
    .drain   (state_q == ST_NORMAL),
    .evt     (evt_in),
    .rel     (evt_rel)
  );

  always_comb begin
    state_d     = state_q;
    from_halt_d = from_halt_q;
    case (state_q)
      ST_NORMAL: begin
        if (stop_req) begin
          state_d     = ST_ACK;
          from_halt_d = 1'b0;
        end else if (halt_exec) begin
          state_d = ST_HALT;
        end
      end
      ST_HALT: begin
        if (stop_req) begin
          state_d     = ST_ACK;
          from_halt_d = 1'b1;
        end else if (|evt_in) begin
          state_d = ST_NORMAL;
        end
      end
      ST_ACK:   if (ack_resp)   state_d = ST_DELAY;
      ST_DELAY: if (entry_done) state_d = ST_GRANT;
      ST_GRANT: begin
        if (!stop_req) begin
          state_d     = from_halt_q ? ST_HALT : ST_NORMAL;
          from_halt_d = 1'b0;
        end else if (snoop_hit) begin
          state_d = ST_SNOOP;
        end
      end
      ST_SNOOP: state_d = ST_GRANT;
      default:  state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= is_parked(state_q) ? ST_GRANT : ST_NORMAL;
      from_halt_q <= 1'b0;
      ack_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      from_halt_q <= from_halt_d;
      ack_q       <= (state_d == ST_ACK);
    end
  end

  assign state_o       = state_q;
  assign ack_cycle_req = ack_q;

  assert_ack_flag_R2: assert property (@(posedge clk) disable iff (rst)
    ack_cycle_req == (state_o == 3'd2));

  assert_request_taken_R2: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_NORMAL || state_q == ST_HALT) && stop_req) |=> (state_q == ST_ACK));

  assert_delay_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DELAY && !entry_done) |=> (state_q == ST_DELAY));

  assert_delay_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DELAY && entry_done) |=> (state_q == ST_GRANT));

  assert_leave_normal_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GRANT && !stop_req && !from_halt_q) |=> (state_q == ST_NORMAL));

  assert_leave_halt_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GRANT && !stop_req && from_halt_q) |=> (state_q == ST_HALT));

  assert_snoop_enter_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GRANT && stop_req && snoop_hit) |=> (state_q == ST_SNOOP));

  assert_snoop_turn_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SNOOP) |=> (state_q == ST_GRANT));

  assert_release_in_normal_R9: assert property (@(posedge clk) disable iff (rst)
    (|evt_rel) |-> ($past(state_q) == ST_NORMAL));

  assert_halt_wake_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT && !stop_req && (|evt_in)) |=> (state_q == ST_NORMAL));

endmodule

// File: tb/clkstop_grant_ctrl_test.sv
module clkstop_grant_ctrl_test;
  localparam int NCLK = 20;

  logic       clk = 1'b0;
  logic       rst, stop_req, ack_resp, snoop_hit, halt_exec;
  logic [3:0] evt_in;
  logic [2:0] state_o;
  logic       ack_cycle_req;
  logic [3:0] evt_rel;

  int  n_chk = 0, n_fail = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  clkstop_grant_ctrl #(.ENTRY_CLKS(NCLK), .NUM_EV(4)) uut (
    .clk, .rst, .stop_req, .ack_resp, .snoop_hit, .halt_exec, .evt_in,
    .state_o, .ack_cycle_req, .evt_rel
  );

  // ---- reference model of the requirements ----
  logic [2:0] m_st = 3'd0;
  int         m_cnt = 0;
  bit         m_fh = 0;
  logic [3:0] m_pend = 4'd0, m_rel = 4'd0;

  function automatic logic [3:0] first_set(input logic [3:0] p);
    for (int i = 0; i < 4; i++) if (p[i]) return 4'(1 << i);
    return 4'd0;
  endfunction

  function automatic string tag_for(input logic [2:0] s);
    case (s)
      3'd0: return "R4";
      3'd1: return "R10";
      3'd2: return "R2";
      3'd3: return "R3";
      default: return "R6";
    endcase
  endfunction

  always @(posedge clk) begin
    logic [2:0] ns;
    logic [3:0] rn;
    bit         parked;
    parked = (m_st == 3'd4) || (m_st == 3'd5);
    if (rst) begin
      m_st = parked ? 3'd4 : 3'd0;
      m_cnt = 0; m_fh = 0; m_pend = 4'd0; m_rel = 4'd0;
    end else begin
      rn = (m_st == 3'd0) ? first_set(m_pend) : 4'd0;
      ns = m_st;
      case (m_st)
        3'd0: if (stop_req) begin ns = 3'd2; m_fh = 0; end
              else if (halt_exec) ns = 3'd1;
        3'd1: if (stop_req) begin ns = 3'd2; m_fh = 1; end
              else if (|evt_in) ns = 3'd0;
        3'd2: if (ack_resp) ns = 3'd3;
        3'd3: if (m_cnt == NCLK) ns = 3'd4;
        3'd4: if (!stop_req) begin ns = m_fh ? 3'd1 : 3'd0; m_fh = 0; end
              else if (snoop_hit) ns = 3'd5;
        default: ns = 3'd4;
      endcase
      if (m_st == 3'd2 && ack_resp) m_cnt = 1;
      else if (m_st == 3'd3 && m_cnt != NCLK) m_cnt = m_cnt + 1;
      m_pend = (m_pend & ~rn) | (parked ? evt_in : 4'd0);
      m_rel = rn;
      m_st = ns;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      check(tag_for(m_st), state_o, m_st);
      check("R2", ack_cycle_req, m_st == 3'd2);
      check("R9", evt_rel, m_rel);
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    stop_req = 0; ack_resp = 0; snoop_hit = 0; halt_exec = 0; evt_in = 4'd0;
  endtask

  // from Normal or Halt with stop_req already high: ack, then wait to Stop Grant
  task automatic enter_grant(output int edges);
    edges = 0;
    for (int i = 0; i < 10 && state_o != 3'd2; i++) step();
    ack_resp = 1; step(); ack_resp = 0;
    check("R3", state_o, 3);
    while (state_o != 3'd4 && edges < 100) begin step(); edges++; end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    int k;
    void'($urandom(32'd4242));
    idle(); rst = 1;
    step(); step();
    check("R1", state_o, 0); check("R1", ack_cycle_req, 0); check("R1", evt_rel, 0);
    rst = 0; step();

    // request, acknowledge timing, latch and release
    stop_req = 1; step();
    check("R2", state_o, 2); check("R2", ack_cycle_req, 1);
    step(); step();
    check("R2", ack_cycle_req, 1);
    enter_grant(k);
    check("R3", k, NCLK);
    evt_in = 4'b1001; step(); evt_in = 4'b0000; step();
    evt_in = 4'b0010; step(); evt_in = 4'b0000; step();
    evt_in = 4'b0011; step(); evt_in = 4'b0000;
    snoop_hit = 1; step(); snoop_hit = 0;
    check("R6", state_o, 5);
    evt_in = 4'b0100; step(); evt_in = 4'b0000;
    check("R6", state_o, 4);
    stop_req = 0; step();
    check("R4", state_o, 0);
    step(); check("R9", evt_rel, 4'b0001);
    step(); check("R9", evt_rel, 4'b0010);
    step(); check("R9", evt_rel, 4'b0100);
    step(); check("R9", evt_rel, 4'b1000);
    step(); check("R8", evt_rel, 4'b0000);

    // halt path
    halt_exec = 1; step(); halt_exec = 0;
    check("R10", state_o, 1);
    snoop_hit = 1; step(); snoop_hit = 0;
    check("R10", state_o, 1);
    stop_req = 1; step();
    check("R2", state_o, 2);
    enter_grant(k);
    check("R3", k, NCLK);
    stop_req = 0; step();
    check("R5", state_o, 1);
    evt_in = 4'b0010; step(); evt_in = 4'b0000;
    check("R10", state_o, 0);
    step(); check("R8", evt_rel, 0);
    step(); check("R8", evt_rel, 0);

    // reset while parked
    halt_exec = 1; step(); halt_exec = 0;
    stop_req = 1; step();
    enter_grant(k);
    evt_in = 4'b0010; step(); evt_in = 4'b0000;
    rst = 1; step(); rst = 0;
    check("R7", state_o, 4);
    snoop_hit = 1; step(); snoop_hit = 0;
    check("R6", state_o, 5);
    rst = 1; step(); rst = 0;
    check("R7", state_o, 4);
    stop_req = 0; step();
    check("R7", state_o, 0);
    step(); check("R7", evt_rel, 0);
    step(); check("R7", evt_rel, 0);

    // reset during entry delay
    stop_req = 1; step(); ack_resp = 1; step(); ack_resp = 0;
    step(); step();
    rst = 1; stop_req = 0; step(); rst = 0;
    check("R1", state_o, 0); check("R1", ack_cycle_req, 0);

    // random phase, checked against the model every cycle
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(39) == 0) stop_req = ~stop_req;
      snoop_hit = ($urandom_range(5) == 0);
      halt_exec = ($urandom_range(7) == 0);
      for (int b = 0; b < 4; b++) evt_in[b] = ($urandom_range(9) == 0);
      ack_resp = (state_o == 3'd2) ? ($urandom_range(2) == 0) : ($urandom_range(19) == 0);
      rst = ($urandom_range(499) == 0);
      step();
    end
    idle(); rst = 0; step();

    finished = 1;
    summary();
    $finish;
  end

endmodule